// File: doc/BRIEF.md
# Fused XOR-Rotate Execution Unit

This unit sits beside the integer datapath of a 32-bit RISC-V core that has the base integer and multiply extensions. It decodes one custom major opcode and executes a small family of register-to-register operations. Each operation XORs two source operands and rotates the XOR left by an amount fixed by the instruction. This is the mixing step of stream-cipher quarter-rounds. Without the unit, that step takes two or more base instructions.

The core presents an instruction word and the two operand values it has already read from the register file, together with an issue strobe. One cycle later the unit returns a registered result, the destination index and a done pulse. It also raises a write-enable when the register file should be updated, or an illegal-instruction flag when the encoding is reserved. Words with a foreign major opcode pass through without any response. The unit never touches memory, and it takes a new issue on every cycle.

Top module: `xrot_unit`

## Requirements
- R1: Only issued words whose bits 6:0 equal 7'b0101011 are accepted. Any other issued word, or a cycle with no issue, gives done, write-enable and illegal all low in the following cycle.
- R2: Fields use the R-type layout: destination in bits 11:7, operation select in bits 14:12 and qualifier in bits 31:25. The result cycle reports the destination field of the accepted word on `rd_idx`. The source index fields in bits 24:15 do not affect the result, because the operands arrive on ports.
- R3: Select 3'b000 returns (src_a XOR src_b) rotated left by 16.
- R4: Select 3'b001 returns (src_a XOR src_b) rotated left by 12.
- R5: Select 3'b010 returns (src_a XOR src_b) rotated left by 8.
- R6: Select 3'b011 returns (src_a XOR src_b) rotated left by 7.
- R7: An accepted word with select 3'b100 to 3'b111 gives done and illegal high and write-enable low.
- R8: An accepted word with a nonzero qualifier field gives done and illegal high and write-enable low, whatever the select value.
- R9: A legal word whose destination is 0 gives done high, with write-enable and illegal both low.
- R10: Outputs for an accepted issue appear exactly one clock after the issuing edge. Issues on consecutive cycles each produce their own result on consecutive cycles.
- R11: After reset, done, write-enable and illegal are low, and result and rd_idx are zero.
- R12: Rotation is circular: bits leaving the most significant end re-enter at the least significant end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction word and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| done | output | 1 | Pulse one cycle after an accepted issue |
| result | output | 32 | Rotated XOR of the accepted operands |
| rd_idx | output | 5 | Destination register index of the completed word |
| rd_we | output | 1 | Register file write request |
| illegal | output | 1 | Reserved encoding in the custom opcode space |

## Verification
The bench builds the unit with its default parameters: 32-bit data, the 7'b0101011 opcode, and rotate amounts 16, 12, 8 and 7 on selects 0 to 3. With these values the bench can compare every select against its own shift-based rotation. Operands with set top bits show the wrap of R12. Near-miss opcodes, the reserved selects and nonzero qualifiers probe the decode edges. A continuous stream of issues, interleaved with idle and foreign words, checks the one-cycle completion order.

// File: rtl/xrot_unit.sv
module xrot_unit #(
  parameter int         DATA_W = 32,
  parameter logic [6:0] OPCODE = 7'b0101011,
  parameter int         ROT_F0 = 16,
  parameter int         ROT_F1 = 12,
  parameter int         ROT_F2 = 8,
  parameter int         ROT_F3 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        rd_idx,
  output logic              rd_we,
  output logic              illegal
);
  localparam int SH_W = $clog2(DATA_W);

  logic [2:0]          sel;
  logic [6:0]          qual;
  logic [4:0]          dst;
  logic                hit, legal;
  logic [SH_W-1:0]     amt;
  logic [DATA_W-1:0]   mixed, rotated;
  logic [2*DATA_W-1:0] dbl;

  assign sel   = instr[14:12];
  assign qual  = instr[31:25];
  assign dst   = instr[11:7];
  assign hit   = issue_valid && (instr[6:0] == OPCODE);
  assign legal = !sel[2] && (qual == 7'd0);

  always_comb begin
    case (sel[1:0])
      2'd0:    amt = SH_W'(ROT_F0);
      2'd1:    amt = SH_W'(ROT_F1);
      2'd2:    amt = SH_W'(ROT_F2);
      default: amt = SH_W'(ROT_F3);
    endcase
  end

  assign mixed   = src_a ^ src_b;
  assign dbl     = {mixed, mixed} << amt;
  assign rotated = dbl[2*DATA_W-1 -: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_we   <= 1'b0;
      illegal <= 1'b0;
      rd_idx  <= '0;
      result  <= '0;
    end else begin
      done    <= hit;
      rd_we   <= hit && legal && (dst != 5'd0);
      illegal <= hit && !legal;
      if (hit) begin
        rd_idx <= dst;
        result <= rotated;
      end
    end
  end
endmodule

module xrot_unit_chk #(
  parameter int         DATA_W = 32,
  parameter logic [6:0] OPCODE = 7'b0101011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        rd_idx,
  input logic              rd_we,
  input logic              illegal
);
  logic              acc;
  logic [DATA_W-1:0] mix_c;
  assign acc   = issue_valid && (instr[6:0] == OPCODE);
  assign mix_c = src_a ^ src_b;

  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!done && !rd_we && !illegal)); // R1
  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> done); // R10
  AST_DEST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rd_idx == $past(instr[11:7])); // R2
  AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && instr[14]) |=> (illegal && !rd_we)); // R7
  AST_BAD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && instr[31:25] != 7'd0) |=> (illegal && !rd_we)); // R8
  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_idx == 5'd0) |-> !rd_we); // R9
  AST_ROT16: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && instr[31:25] == 7'd0 && instr[14:12] == 3'd0) |=>
      result == (($past(mix_c) << 16) | ($past(mix_c) >> (DATA_W-16)))); // R3
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_we && illegal)); // R7
endmodule

bind xrot_unit xrot_unit_chk #(.DATA_W(DATA_W), .OPCODE(OPCODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
  .src_a(src_a), .src_b(src_b), .done(done), .result(result),
  .rd_idx(rd_idx), .rd_we(rd_we), .illegal(illegal)
);

// File: tb/sim_xrot_unit.sv
module sim_xrot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0, src_a = '0, src_b = '0;
  logic        done, rd_we, illegal;
  logic [31:0] result;
  logic [4:0]  rd_idx;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic        d, we, ill, chk_res;
    logic [4:0]  rd;
    logic [31:0] res;
  } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];

  always #4 clk = ~clk;

  xrot_unit u0 (.clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .done(done), .result(result), .rd_idx(rd_idx),
    .rd_we(rd_we), .illegal(illegal));

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] rs2,
    input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  task automatic drive(input logic v, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    exp_t e;
    logic hit, ok;
    int n;
    @(negedge clk);
    issue_valid = v; instr = ins; src_a = a; src_b = b;
    hit = v && (ins[6:0] == 7'b0101011);
    ok  = !ins[14] && (ins[31:25] == 7'd0);
    case (ins[13:12]) 2'd0: n = 16; 2'd1: n = 12; 2'd2: n = 8; default: n = 7; endcase
    e.d = hit;
    e.ill = hit && !ok;
    e.we = hit && ok && (ins[11:7] != 5'd0);
    e.rd = ins[11:7];
    e.res = rotl(a ^ b, n);
    e.chk_res = hit && ok;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q_exp.size() > 0) begin
      exp_t e;
      string t;
      bit ok;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      ok = (done == e.d) && (rd_we == e.we) && (illegal == e.ill);
      if (e.d) ok = ok && (rd_idx == e.rd);
      if (e.chk_res) ok = ok && (result == e.res);
      chk(ok, t, {23'd0, done, rd_we, illegal, rd_idx, result},
                 {23'd0, e.d, e.we, e.ill, e.rd, e.res});
    end
  end

  localparam logic [6:0] OP = 7'b0101011;

  initial begin
    #20;
    chk(done == 0 && rd_we == 0 && illegal == 0, "R11", {61'd0, done, rd_we, illegal}, 0);
    chk(result == 0 && rd_idx == 0, "R11", {27'd0, rd_idx, result}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R3 R4 R5 R6
    drive(1, mk(0, 5'd2, 5'd1, 3'd0, 5'd3, OP), 32'h1234_5678, 32'h0F0F_0F0F, "R3");
    drive(1, mk(0, 5'd4, 5'd9, 3'd1, 5'd5, OP), 32'hDEAD_BEEF, 32'h0000_FFFF, "R4");
    drive(1, mk(0, 5'd7, 5'd8, 3'd2, 5'd6, OP), 32'hA5A5_0000, 32'h00FF_00FF, "R5");
    drive(1, mk(0, 5'd1, 5'd2, 3'd3, 5'd7, OP), 32'hCAFE_F00D, 32'h1357_9BDF, "R6");
    // R12: top bits wrap
    drive(1, mk(0, 5'd0, 5'd0, 3'd3, 5'd9, OP), 32'h8000_0001, 32'h0, "R12");
    drive(1, mk(0, 5'd0, 5'd0, 3'd0, 5'd9, OP), 32'hFFFF_0000, 32'h0, "R12");
    // R1: foreign opcodes, idle, near miss
    drive(1, mk(0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0110011), 32'h1, 32'h2, "R1");
    drive(1, mk(0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0101010), 32'h1, 32'h2, "R1");
    drive(0, mk(0, 5'd2, 5'd1, 3'd0, 5'd3, OP), 32'h1, 32'h2, "R1");
    drive(1, mk(0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0001011), 32'h1, 32'h2, "R1");
    // R7 reserved selects
    for (int f = 4; f < 8; f++)
      drive(1, mk(0, 5'd2, 5'd1, 3'(f), 5'd4, OP), 32'h5, 32'h6, "R7");
    // R8 nonzero qualifier
    drive(1, mk(7'h01, 5'd2, 5'd1, 3'd0, 5'd4, OP), 32'h5, 32'h6, "R8");
    drive(1, mk(7'h40, 5'd2, 5'd1, 3'd2, 5'd4, OP), 32'h5, 32'h6, "R8");
    // R9 destination zero
    drive(1, mk(0, 5'd2, 5'd1, 3'd1, 5'd0, OP), 32'h1111_2222, 32'h3, "R9");
    // R2 source fields irrelevant, destination echoed
    drive(1, mk(0, 5'd31, 5'd31, 3'd2, 5'd31, OP), 32'h0BAD_F00D, 32'h7, "R2");
    drive(1, mk(0, 5'd0, 5'd0, 3'd2, 5'd17, OP), 32'h0BAD_F00D, 32'h7, "R2");
    // R10 back-to-back stream with gaps
    for (int i = 0; i < 24; i++) begin
      if (i % 5 == 4)
        drive(0, 32'h0, 32'h0, 32'h0, "R10");
      else
        drive(1, mk(0, 5'(i), 5'(i+1), 3'(i % 4), 5'(i + 1), OP),
              32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ i, "R10");
    end
    drive(0, 32'h0, 32'h0, 32'h0, "R10");
    @(negedge clk); issue_valid = 0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule